// File: doc/BRIEF.md
# Two-Wire Indexed Register Write Slave

This block is a write-only target on a two-wire serial bus. Its system clock oversamples the bus clock line and the bus data line. It finds the bus conditions that open and close a frame, and it shifts in one address byte and two data bytes. It acknowledges each byte by pulling the data line low through an open-drain enable.

The last two bits of the seven-bit bus address select which of three 16-bit control registers the frame writes. The bits above them are fixed identity bits and a strap input. The strap sets the two most significant address bits. Each accepted frame carries exactly one 16-bit word. The word reaches its register in one step, only after the third acknowledge. A one-cycle strobe marks that moment and reports which register was written.

The block has no read path and never stretches the bus clock. It does not check bus timing, and it gives no meaning to the register contents.

Top module: `ctlw_slave`

## Requirements
- R1: Both bus lines pass through a two-flop synchronizer. A frame opens when the data line falls while the clock line is high. A frame closes when the data line rises while the clock line is high.
- R2: Every byte is received most significant bit first, with each bit sampled on the rising edge of the synchronized clock line. The address byte is seven address bits followed by a direction bit, where 0 means write.
- R3: The address is accepted only when it equals {S, S, 1, 0, 0, i1, i0}, where S is the strap input level and i1:i0 is the register index. With S low the accepted addresses are 0x10, 0x11 and 0x12. With S high they are 0x70, 0x71 and 0x72.
- R4: Index 00 selects register 0, index 01 selects register 1 and index 10 selects register 2. Index 11 is rejected.
- R5: A frame whose direction bit is 1 is rejected, even when its address matches.
- R6: For an accepted frame, the slave pulls the data line low during the acknowledge bit after the address byte and during the acknowledge bit after each data byte. The slave changes the open-drain enable only while the clock line is low.
- R7: For a rejected frame, the slave leaves the data line released during the address acknowledge. It then drives nothing and stores nothing until the next start.
- R8: The first data byte is bits 15..8 of the word and the second is bits 7..0. The selected register takes the full word in a single cycle at the end of the third acknowledge. At the same time the one-cycle strobe rises with wr_idx set to the register index. The other registers keep their values.
- R9: A stop that arrives before the end of the third acknowledge discards the partial word. No register changes and no strobe is given.
- R10: A start seen in the middle of a frame abandons that frame, with no register changed, and begins a new address phase.
- R11: While reset is active, all three registers read zero, the strobe is low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Strap level that sets the two upper address bits |
| scl_in | input | 1 | Bus clock line, asynchronous to clk |
| sda_in | input | 1 | Bus data line as seen on the pad, asynchronous to clk |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| wr_stb | output | 1 | One-cycle pulse when a register takes a new word |
| wr_idx | output | 2 | Index of the register written, valid with wr_stb |
| reg0_q | output | 16 | Contents of register 0 |
| reg1_q | output | 16 | Contents of register 1 |
| reg2_q | output | 16 | Contents of register 2 |

## Verification
The bench sweeps all 128 addresses under both strap levels. A shifted address comparison or an off-by-one bit counter shows up at once at the ports. It appears as a wrong acknowledge level on the first acknowledge bit, about one bus bit time after the byte ends. A sequencer stuck in the wrong phase shows later, as a missing second or third acknowledge or as a word in the wrong register or in the wrong byte order, which can be seen a few cycles after the frame closes. A commit path that leaks is found by the aborted frames: a stop or a repeated start after the first data byte would show a changed register or an extra strobe.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int NREG   = 3;
  localparam int IDX_W  = 2;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACKA, ST_HI, ST_ACKH, ST_LO, ST_ACKL, ST_SKIP
  } ctlw_state_e;

  function automatic logic addr_hit(input logic strap,
                                    input logic [ADDR_W-1:0] a,
                                    input logic rw);
    return (a[ADDR_W-1:IDX_W] == {strap, strap, 3'b100}) &&
           (a[IDX_W-1:0] < IDX_W'(NREG)) && !rw;
  endfunction
endpackage

// File: rtl/ctlw_sync.sv
module ctlw_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] prv
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain    <= '1;
        prv[l]   <= 1'b1;
      end else begin
        chain    <= {chain[STAGES-2:0], raw[l]};
        prv[l]   <= chain[STAGES-1];
      end
    end
    assign lvl[l] = chain[STAGES-1];
  end
endmodule

// File: rtl/ctlw_frame.sv
module ctlw_frame
  import ctlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic              scl_s,
  input  logic              scl_p,
  input  logic              sda_s,
  input  logic              sda_p,
  output logic              oe,
  output logic              we,
  output logic [IDX_W-1:0]  widx,
  output logic [WORD_W-1:0] wdata
);
  ctlw_state_e       st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] byte_in;
  logic              rise, fall, start_c, stop_c, last_bit;

  assign rise     = scl_s & ~scl_p;
  assign fall     = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign byte_in  = {sh[BYTE_W-2:0], sda_s};
  assign last_bit = (cnt == CNT_W'(BYTE_W - 1));
  assign wdata    = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      sh   <= '0;
      hi_q <= '0;
      lo_q <= '0;
      widx <= '0;
      oe   <= 1'b0;
      we   <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_c) begin
        st  <= ST_ADDR;
        cnt <= '0;
        oe  <= 1'b0;
      end else if (stop_c) begin
        st  <= ST_IDLE;
        oe  <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_HI, ST_LO: begin
            if (rise) begin
              sh  <= byte_in;
              cnt <= cnt + 1'b1;
              if (last_bit) begin
                if (st == ST_ADDR) begin
                  if (addr_hit(strap, byte_in[BYTE_W-1:1], byte_in[0])) begin
                    widx <= byte_in[IDX_W:1];
                    st   <= ST_ACKA;
                  end else begin
                    st   <= ST_SKIP;
                  end
                end else if (st == ST_HI) begin
                  hi_q <= byte_in;
                  st   <= ST_ACKH;
                end else begin
                  lo_q <= byte_in;
                  st   <= ST_ACKL;
                end
              end
            end
          end
          ST_ACKA, ST_ACKH, ST_ACKL: begin
            if (fall) begin
              if (!oe) begin
                oe <= 1'b1;
              end else begin
                oe  <= 1'b0;
                cnt <= '0;
                if (st == ST_ACKA)      st <= ST_HI;
                else if (st == ST_ACKH) st <= ST_LO;
                else begin
                  we <= 1'b1;
                  st <= ST_SKIP;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !$past(scl_s)); // R6
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(oe) && !$past(start_c) && !$past(stop_c)) |-> !$past(scl_s)); // R6
  AST_NO_DRIVE_OUTSIDE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_SKIP || st == ST_ADDR) |-> !oe); // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we); // R8
  AST_STROBE_INDEX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (widx < IDX_W'(NREG))); // R4
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == ST_ADDR && !oe && !we)); // R10
endmodule

// File: rtl/ctlw_regbank.sv
module ctlw_regbank
  import ctlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q [NREG]
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q[i] <= '0;
      else if (we && idx == IDX_W'(i))     q[i] <= d;
    end

    AST_HOLD_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && idx == IDX_W'(i)) |=> $stable(q[i])); // R8
  end
endmodule

// File: rtl/ctlw_slave.sv
module ctlw_slave
  import ctlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_strap,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [1:0]        wr_idx,
  output logic [15:0]       reg0_q,
  output logic [15:0]       reg1_q,
  output logic [15:0]       reg2_q
);
  logic [1:0]        lvl, prv;
  logic              we;
  logic [IDX_W-1:0]  widx;
  logic [WORD_W-1:0] wdata;
  logic [WORD_W-1:0] q [NREG];

  ctlw_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .lvl(lvl), .prv(prv)
  );

  ctlw_frame u_frame (
    .clk(clk), .rst_n(rst_n), .strap(addr_strap),
    .scl_s(lvl[1]), .scl_p(prv[1]), .sda_s(lvl[0]), .sda_p(prv[0]),
    .oe(sda_oe), .we(we), .widx(widx), .wdata(wdata)
  );

  ctlw_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .idx(widx), .d(wdata), .q(q)
  );

  assign wr_stb = we;
  assign wr_idx = widx;
  assign reg0_q = q[0];
  assign reg1_q = q[1];
  assign reg2_q = q[2];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!sda_oe && !wr_stb && reg0_q == '0 && reg1_q == '0 && reg2_q == '0)); // R11
endmodule

// File: tb/ctlw_slave_test.sv
module ctlw_slave_test;
  localparam int QC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_stb;
  logic [1:0] wr_idx;
  logic [15:0] r0, r1, r2;
  logic sda_bus;

  int tests = 0;
  int fails = 0;
  int stb_cnt = 0;
  logic [1:0] last_idx = 2'd0;
  logic [15:0] expv [3];

  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  ctlw_slave uut (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_in(scl_m),
    .sda_in(sda_bus), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .reg0_q(r0), .reg1_q(r1), .reg2_q(r2)
  );

  always @(posedge clk) if (wr_stb) begin
    stb_cnt <= stb_cnt + 1;
    last_idx <= wr_idx;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic q();
    repeat (QC) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_bus; q(); scl_m = 1'b0; q();
  endtask

  // mode 0: full frame + stop, 1: stop after first data byte, 2: leave open after first data byte
  task automatic frame(input logic [6:0] a, input logic rw, input logic [15:0] d,
                       input int mode, output logic [2:0] acks);
    logic k;
    acks = 3'b000;
    bus_start();
    send_byte({a, rw}, k); acks[0] = k;
    send_byte(d[15:8], k); acks[1] = k;
    if (mode == 0) begin
      send_byte(d[7:0], k); acks[2] = k;
    end
    if (mode != 2) bus_stop();
    repeat (8) @(negedge clk);
  endtask

  task automatic chk_regs(input string req);
    chk(req, {16'd0, r0}, {16'd0, expv[0]});
    chk(req, {16'd0, r1}, {16'd0, expv[1]});
    chk(req, {16'd0, r2}, {16'd0, expv[2]});
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap = s; scl_m = 1'b1; sda_m = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 oe", {31'd0, sda_oe}, 32'd0);
    chk("R11 stb", {31'd0, wr_stb}, 32'd0);
    for (int i = 0; i < 3; i++) expv[i] = 16'd0;
    chk_regs("R11 regs");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic hit;
    int s0;
    logic [15:0] d;
    // R1 R2 R3 R4 R6 R7 R8: sweep every address under both strap levels
    for (int s = 0; s < 2; s++) begin
      do_reset(s[0]);
      for (int a = 0; a < 128; a++) begin
        d = 16'(a * 509 + s * 7919 + 16'h1234);
        hit = (a[6:2] == {s[0], s[0], 3'b100}) && (a[1:0] != 2'b11);
        s0 = stb_cnt;
        frame(a[6:0], 1'b0, d, 0, acks);
        if (hit) expv[a[1:0]] = d;
        chk("R3 R4 addr ack", {29'd0, acks}, hit ? 32'd7 : 32'd0);
        chk("R8 strobe count", stb_cnt - s0, hit ? 32'd1 : 32'd0);
        if (hit) chk("R8 strobe index", {30'd0, last_idx}, {30'd0, a[1:0]});
        chk_regs("R2 R7 R8 regs");
      end
    end
    // R5: read direction rejected on matching addresses
    for (int i = 0; i < 3; i++) begin
      s0 = stb_cnt;
      frame({5'b11100, i[1:0]}, 1'b1, 16'hdead, 0, acks);
      chk("R5 nack", {29'd0, acks}, 32'd0);
      chk("R5 no strobe", stb_cnt - s0, 32'd0);
      chk_regs("R5 regs");
    end
    // R9: stop after high byte discards
    s0 = stb_cnt;
    frame(7'h71, 1'b0, 16'hbeef, 1, acks);
    chk("R9 acks", {29'd0, acks}, 32'd3);
    chk("R9 no strobe", stb_cnt - s0, 32'd0);
    chk_regs("R9 regs");
    // R10: repeated start mid-frame, then a complete frame to another register
    s0 = stb_cnt;
    frame(7'h70, 1'b0, 16'hcafe, 2, acks);
    chk("R10 first acks", {29'd0, acks}, 32'd3);
    frame(7'h72, 1'b0, 16'h5a3c, 0, acks);
    expv[2] = 16'h5a3c;
    chk("R10 second acks", {29'd0, acks}, 32'd7);
    chk("R10 one strobe", stb_cnt - s0, 32'd1);
    chk_regs("R10 regs");
    // R6: oe released once the frame is closed
    chk("R6 released", {31'd0, sda_oe}, 32'd0);
    do_reset(1'b0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule